// File: doc/BRIEF.md
# VID Reference and Voltage Window Monitor

This block turns a 5-bit voltage-identification code into a target core voltage in millivolts. It holds a working reference that starts at zero and moves toward that target by a fixed amount on each step-enable pulse. The working reference drives the regulation loop, which lies outside this block. The block also compares a digitized sense voltage, already scaled to millivolts, against windows derived from the target. From those comparisons it raises an overvoltage flag, an undervoltage flag and a power-good flag, and the two fault flags carry hysteresis.

The code map is inverted. The all-ones code switches the output off. Each step down from the next code adds a fixed voltage, so code 30 gives the lowest voltage and code 0 the highest. A code change after start-up takes effect on the target at once. The working reference then walks to the new value at the ramp rate, in either direction. All window tests are exact integer comparisons of the sense value scaled by 100 against the target scaled by a percentage. A sense value that sits exactly on a threshold therefore resolves predictably.

Top module: `vid_window_monitor`

## Requirements
- R1: Code 5'b11111 is the off code. Within three clocks of applying it, `off_o` is 1, `ref_mv_o` is 0 and `ov_o`, `uv_o` and `pg_o` are all 0, whatever the sense value is. When a valid code returns, the reference ramps again from 0.
- R2: Any other code c gives the target 950 + 25*(30-c) mV: code 30 gives 950 mV and code 0 gives 1700 mV. The ramp settles on exactly this value.
- R3: On each clock with `step_en_i` high, the working reference moves toward the target by RAMP_STEP_MV (default 25 mV) and never passes it. With `step_en_i` low it holds its value.
- R4: After a code change, the working reference steps from its present value toward the new target, whether that target is higher or lower.
- R5: `ov_o` sets one clock after a sample with sense*100 > target*115. A sense value exactly at 115% does not set it.
- R6: Once set, `ov_o` stays high while sense*100 >= target*113. It clears one clock after a sample below 113%.
- R7: `uv_o` sets one clock after a sample with sense*100 < target*91. A sense value exactly at 91% does not set it.
- R8: Once set, `uv_o` stays high while sense*100 <= target*93. It clears one clock after a sample above 93%, because the flag is not latched.
- R9: `pg_o` is 1 one clock after a sample with sense*100 >= target*96, provided the working reference equals the target, the output is not off and overvoltage is not flagged. At most one of `ov_o`, `uv_o` and `pg_o` is high at any time.
- R10: While `rst` is high, `ref_mv_o` is 0, `off_o` is 1 and the three window flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_i | input | VID_W (5) | Voltage-identification code |
| step_en_i | input | 1 | Ramp step enable, one step per high clock |
| sense_mv_i | input | MV_W (12) | Sampled sense voltage in mV |
| ref_mv_o | output | MV_W (12) | Working reference in mV |
| off_o | output | 1 | Output-off flag |
| ov_o | output | 1 | Overvoltage flag, with hysteresis |
| uv_o | output | 1 | Undervoltage flag, with hysteresis |
| pg_o | output | 1 | In-window (power-good) flag |

## Verification
The bench places the sense value exactly on each threshold and then one millivolt past it. It does this at 115% and 113% for overvoltage, at 91% and 93% for undervoltage, and at 96% for power good. A design that rounds the wrong way, or that uses >= where > is required, flips a flag one step early. The bench parks the sense value inside each hysteresis band. A design without hysteresis drops the flag there, and a latched undervoltage never clears. The ramp is walked up, up again to the top code, and down, so that a reference that overshoots, skips its final clamp, or ignores a lower target shows the wrong value at a specific step. Off-code entry is applied with a sense value that would otherwise trip overvoltage, and exit is checked for a restart from zero. Power good is checked while the reference is still catching up with a new target, which catches a design that forgets the ramp gate.

// File: rtl/vwm_pkg.sv
package vwm_pkg;

  typedef struct packed {
    logic ov;
    logic uv;
    logic pg;
  } win_flags_t;

  // Inverted code map: the highest valid code gives base, each lower code adds one step
  function automatic int unsigned code_to_mv(input int unsigned code,
                                             input int unsigned top_valid,
                                             input int unsigned base_mv,
                                             input int unsigned step_mv);
    return base_mv + step_mv * (top_valid - code);
  endfunction

endpackage

// File: rtl/vwm_vid_decode.sv
module vwm_vid_decode #(
  parameter int unsigned VID_W   = 5,
  parameter int unsigned MV_W    = 12,
  parameter int unsigned BASE_MV = 950,
  parameter int unsigned STEP_MV = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VID_W-1:0] vid_i,
  output logic [MV_W-1:0]  target_o,
  output logic             off_o
);
  import vwm_pkg::*;

  localparam int unsigned       N_CODES   = 2 ** VID_W;
  localparam int unsigned       TOP_VALID = N_CODES - 2;
  localparam logic [VID_W-1:0]  OFF_CODE  = '1;
  localparam logic [MV_W-1:0]   BASE_W    = MV_W'(BASE_MV);
  localparam logic [MV_W-1:0]   STEP_W    = MV_W'(STEP_MV);
  localparam logic [MV_W-1:0]   MAX_W     = MV_W'(BASE_MV + STEP_MV * TOP_VALID);

  logic [MV_W-1:0] target_q;
  logic            off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= '0;
      off_q    <= 1'b1;
    end else if (vid_i == OFF_CODE) begin
      target_q <= '0;
      off_q    <= 1'b1;
    end else begin
      target_q <= MV_W'(code_to_mv(32'(vid_i), TOP_VALID, BASE_MV, STEP_MV));
      off_q    <= 1'b0;
    end
  end

  assign target_o = target_q;
  assign off_o    = off_q;

  // R1
  off_code_chk: assert property (@(posedge clk) disable iff (rst)
    (vid_i == OFF_CODE) |=> off_q);

  // R2
  target_grid_chk: assert property (@(posedge clk) disable iff (rst)
    !off_q |-> (target_q >= BASE_W && target_q <= MAX_W &&
                ((target_q - BASE_W) % STEP_W) == '0));

endmodule

// File: rtl/vwm_ref_ramp.sv
module vwm_ref_ramp #(
  parameter int unsigned MV_W         = 12,
  parameter int unsigned RAMP_STEP_MV = 25
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            off_i,
  input  logic [MV_W-1:0] target_i,
  input  logic            step_i,
  output logic [MV_W-1:0] ref_o,
  output logic            done_o
);

  logic [MV_W-1:0] ref_q;
  logic [MV_W-1:0] ref_nxt;

  generate
    if (RAMP_STEP_MV == 0) begin : g_follow
      // No ramp: the reference tracks the target on the next clock
      always_comb begin
        ref_nxt = off_i ? '0 : target_i;
      end
    end else begin : g_ramp
      localparam logic [MV_W-1:0] STEP = MV_W'(RAMP_STEP_MV);

      always_comb begin
        ref_nxt = ref_q;
        if (off_i) begin
          ref_nxt = '0;
        end else if (step_i) begin
          if (ref_q < target_i) begin
            if ((target_i - ref_q) <= STEP) ref_nxt = target_i;
            else                            ref_nxt = ref_q + STEP;
          end else if (ref_q > target_i) begin
            if ((ref_q - target_i) <= STEP) ref_nxt = target_i;
            else                            ref_nxt = ref_q - STEP;
          end
        end
      end

      // R3
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!off_i && !step_i) |=> $stable(ref_q));

      // R3
      step_size_chk: assert property (@(posedge clk) disable iff (rst)
        !off_i |=> ((ref_q - $past(ref_q)) <= STEP) || (($past(ref_q) - ref_q) <= STEP));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ref_q <= '0;
    else     ref_q <= ref_nxt;
  end

  assign ref_o  = ref_q;
  assign done_o = (ref_q == target_i);

  // R1
  off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    off_i |=> (ref_q == '0));

endmodule

// File: rtl/vwm_window.sv
module vwm_window #(
  parameter int unsigned MV_W    = 12,
  parameter int unsigned OV_PCT  = 15,
  parameter int unsigned UV_PCT  = 9,
  parameter int unsigned PG_PCT  = 4,
  parameter int unsigned HYS_PCT = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                off_i,
  input  logic                done_i,
  input  logic [MV_W-1:0]     target_i,
  input  logic [MV_W-1:0]     sense_i,
  output vwm_pkg::win_flags_t flags_o
);
  import vwm_pkg::*;

  localparam int unsigned PW = MV_W + 8;
  localparam logic [PW-1:0] K_UNIT   = PW'(100);
  localparam logic [PW-1:0] K_OV_SET = PW'(100 + OV_PCT);
  localparam logic [PW-1:0] K_OV_CLR = PW'(100 + OV_PCT - HYS_PCT);
  localparam logic [PW-1:0] K_UV_SET = PW'(100 - UV_PCT);
  localparam logic [PW-1:0] K_UV_CLR = PW'(100 - UV_PCT + HYS_PCT);
  localparam logic [PW-1:0] K_PG     = PW'(100 - PG_PCT);

  logic [PW-1:0] s100, t_ovs, t_ovc, t_uvs, t_uvc, t_pg;
  win_flags_t    flg_q, flg_nxt;

  always_comb begin
    s100  = PW'(sense_i)  * K_UNIT;
    t_ovs = PW'(target_i) * K_OV_SET;
    t_ovc = PW'(target_i) * K_OV_CLR;
    t_uvs = PW'(target_i) * K_UV_SET;
    t_uvc = PW'(target_i) * K_UV_CLR;
    t_pg  = PW'(target_i) * K_PG;
  end

  always_comb begin
    flg_nxt = '0;
    if (!off_i) begin
      flg_nxt.ov = flg_q.ov ? (s100 >= t_ovc) : (s100 > t_ovs);
      flg_nxt.uv = flg_q.uv ? (s100 <= t_uvc) : (s100 < t_uvs);
      flg_nxt.pg = done_i && (s100 >= t_pg) && !flg_nxt.ov;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flg_q <= '0;
    else     flg_q <= flg_nxt;
  end

  assign flags_o = flg_q;

  // R5
  ov_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!off_i && s100 > t_ovs) |=> flg_q.ov);

  // R6
  ov_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_q.ov && !off_i && s100 >= t_ovc) |=> flg_q.ov);

  // R7
  uv_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!off_i && s100 < t_uvs) |=> flg_q.uv);

  // R8
  uv_release_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_q.uv && !off_i && s100 > t_uvc) |=> !flg_q.uv);

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flg_q.ov, flg_q.uv, flg_q.pg}));

  // R1
  off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    off_i |=> (flg_q == '0));

endmodule

// File: rtl/vid_window_monitor.sv
module vid_window_monitor #(
  parameter int unsigned VID_W        = 5,
  parameter int unsigned MV_W         = 12,
  parameter int unsigned BASE_MV      = 950,
  parameter int unsigned STEP_MV      = 25,
  parameter int unsigned RAMP_STEP_MV = 25,
  parameter int unsigned OV_PCT       = 15,
  parameter int unsigned UV_PCT       = 9,
  parameter int unsigned PG_PCT       = 4,
  parameter int unsigned HYS_PCT      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VID_W-1:0] vid_i,
  input  logic             step_en_i,
  input  logic [MV_W-1:0]  sense_mv_i,
  output logic [MV_W-1:0]  ref_mv_o,
  output logic             off_o,
  output logic             ov_o,
  output logic             uv_o,
  output logic             pg_o
);
  import vwm_pkg::*;

  logic [MV_W-1:0] target;
  logic            off;
  logic            done;
  win_flags_t      flags;

  vwm_vid_decode #(
    .VID_W(VID_W), .MV_W(MV_W), .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
  ) dec_i (
    .clk(clk), .rst(rst), .vid_i(vid_i), .target_o(target), .off_o(off)
  );

  vwm_ref_ramp #(
    .MV_W(MV_W), .RAMP_STEP_MV(RAMP_STEP_MV)
  ) ramp_i (
    .clk(clk), .rst(rst), .off_i(off), .target_i(target), .step_i(step_en_i),
    .ref_o(ref_mv_o), .done_o(done)
  );

  vwm_window #(
    .MV_W(MV_W), .OV_PCT(OV_PCT), .UV_PCT(UV_PCT), .PG_PCT(PG_PCT), .HYS_PCT(HYS_PCT)
  ) win_i (
    .clk(clk), .rst(rst), .off_i(off), .done_i(done), .target_i(target),
    .sense_i(sense_mv_i), .flags_o(flags)
  );

  assign off_o = off;
  assign ov_o  = flags.ov;
  assign uv_o  = flags.uv;
  assign pg_o  = flags.pg;

  // R10
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (ref_mv_o == '0 && off_o && !ov_o && !uv_o && !pg_o));

endmodule

// File: tb/vid_window_monitor_tb_top.sv
module vid_window_monitor_tb_top;

  localparam int MV = 12;
  localparam logic [4:0] C_REF = 5'b00001, C_OFF = 5'b00010, C_OV = 5'b00100,
                         C_UV = 5'b01000, C_PG = 5'b10000, C_ALL = 5'b11111;

  typedef struct {
    int         refv;
    logic       off, ov, uv, pg;
    logic [4:0] care;
    string      tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst;
  logic [4:0]    vid;
  logic          step_en;
  logic [MV-1:0] sense;
  logic [MV-1:0] ref_mv;
  logic          off, ov, uv, pg;

  int   n_run  = 0;
  int   n_fail = 0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  vid_window_monitor dut_i (
    .clk(clk), .rst(rst), .vid_i(vid), .step_en_i(step_en), .sense_mv_i(sense),
    .ref_mv_o(ref_mv), .off_o(off), .ov_o(ov), .uv_o(uv), .pg_o(pg)
  );

  function automatic int tgt(input int code);
    return 950 + 25 * (30 - code);
  endfunction

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_out(input string tag, input logic [4:0] care, input int refv,
                            input logic e_off, input logic e_ov, input logic e_uv,
                            input logic e_pg);
    exp_t e;
    e.refv = refv; e.off = e_off; e.ov = e_ov; e.uv = e_uv; e.pg = e_pg;
    e.care = care; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk); #1;
  endtask

  // Monitor: compares outputs with the queued expectation between clock edges
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        int   bad;
        e = sb_q.pop_front();
        bad = 0;
        if (e.care[0] && int'(ref_mv) != e.refv) begin
          $display("FAIL %s ref_mv actual %0d expected %0d", e.tag, ref_mv, e.refv); bad++;
        end
        if (e.care[1] && off !== e.off) begin
          $display("FAIL %s off actual %0b expected %0b", e.tag, off, e.off); bad++;
        end
        if (e.care[2] && ov !== e.ov) begin
          $display("FAIL %s ov actual %0b expected %0b", e.tag, ov, e.ov); bad++;
        end
        if (e.care[3] && uv !== e.uv) begin
          $display("FAIL %s uv actual %0b expected %0b", e.tag, uv, e.uv); bad++;
        end
        if (e.care[4] && pg !== e.pg) begin
          $display("FAIL %s pg actual %0b expected %0b", e.tag, pg, e.pg); bad++;
        end
        n_run++;
        if (bad != 0) n_fail++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int e;
    rst = 1'b1; vid = 5'h1f; step_en = 1'b0; sense = '0;
    tick(3);
    expect_out("R10 reset state", C_ALL, 0, 1, 0, 0, 0);

    rst = 1'b0; vid = 5'd28;            // target 1000 mV
    tick(3);
    expect_out("R3 hold without enable", C_REF | C_OFF | C_PG, 0, 0, 0, 0, 0);

    step_en = 1'b1;
    for (int k = 1; k <= 42; k++) begin
      tick(1);
      e = (25 * k > 1000) ? 1000 : 25 * k;
      expect_out("R3 R2 ramp up to 1000", C_REF, e, 0, 0, 0, 0);
    end
    step_en = 1'b0;
    tick(2);

    sense = 12'd1000; tick(1);
    expect_out("R9 in window at target", C_ALL, 1000, 0, 0, 0, 1);
    sense = 12'd960;  tick(1);
    expect_out("R9 pg at exactly 96%", C_OV | C_UV | C_PG, 0, 0, 0, 0, 1);
    sense = 12'd959;  tick(1);
    expect_out("R9 pg drops below 96%", C_OV | C_UV | C_PG, 0, 0, 0, 0, 0);

    sense = 12'd1150; tick(1);
    expect_out("R5 no ov at exactly 115%", C_OV | C_PG, 0, 0, 0, 0, 1);
    sense = 12'd1151; tick(1);
    expect_out("R5 ov above 115%", C_OV | C_PG, 0, 0, 1, 0, 0);
    sense = 12'd1130; tick(1);
    expect_out("R6 ov held at 113%", C_OV | C_PG, 0, 0, 1, 0, 0);
    sense = 12'd1129; tick(1);
    expect_out("R6 ov released below 113%", C_OV | C_PG, 0, 0, 0, 0, 1);

    sense = 12'd910; tick(1);
    expect_out("R7 no uv at exactly 91%", C_UV, 0, 0, 0, 0, 0);
    sense = 12'd909; tick(1);
    expect_out("R7 uv below 91%", C_UV | C_PG, 0, 0, 0, 1, 0);
    sense = 12'd930; tick(1);
    expect_out("R8 uv held at 93%", C_UV, 0, 0, 0, 1, 0);
    sense = 12'd931; tick(1);
    expect_out("R8 uv released above 93%", C_UV | C_PG, 0, 0, 0, 0, 0);

    vid = 5'd24;                         // target 1100 mV
    tick(2);
    expect_out("R4 reference waits for enable", C_REF, 1000, 0, 0, 0, 0);
    sense = 12'd1100; tick(1);
    expect_out("R9 pg gated while ramping", C_REF | C_PG, 1000, 0, 0, 0, 0);
    step_en = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      tick(1);
      expect_out("R4 ramp up to new target", C_REF, 1000 + 25 * k, 0, 0, 0, 0);
    end
    step_en = 1'b0;
    tick(1);
    expect_out("R9 pg after ramp done", C_REF | C_PG, 1100, 0, 0, 0, 1);

    vid = 5'd30;                         // target 950 mV
    tick(2);
    step_en = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      tick(1);
      e = (1100 - 25 * k < 950) ? 950 : 1100 - 25 * k;
      expect_out("R4 R2 ramp down to 950", C_REF, e, 0, 0, 0, 0);
    end
    step_en = 1'b0;

    vid = 5'd0;                          // target 1700 mV
    tick(2);
    step_en = 1'b1;
    for (int k = 1; k <= 32; k++) begin
      tick(1);
      e = (950 + 25 * k > tgt(0)) ? tgt(0) : 950 + 25 * k;
      if (k % 4 == 0 || k >= 29)
        expect_out("R2 ramp up to top code", C_REF, e, 0, 0, 0, 0);
    end
    step_en = 1'b0;

    vid = 5'h1f; sense = 12'd2000;
    tick(3);
    expect_out("R1 off code clears all", C_ALL, 0, 1, 0, 0, 0);
    tick(2);
    expect_out("R1 high sense ignored while off", C_ALL, 0, 1, 0, 0, 0);

    vid = 5'd28; sense = '0;
    tick(2);
    expect_out("R1 leaves off state", C_REF | C_OFF, 0, 0, 0, 0, 0);
    step_en = 1'b1; tick(1); step_en = 1'b0;
    expect_out("R1 R3 restart from zero", C_REF, 25, 0, 0, 0, 0);

    tick(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule